// File: doc/BRIEF.md
# Radix-4 Booth Carry-Save Compression Step

This block is the arithmetic core of one iteration of an iterative 32x32 multiplier. It takes the redundant running result from the previous iteration as a sum vector and a carry vector. It also takes the multiplicand, an 8-bit window of the multiplier with the bit just beneath that window, and a signed/unsigned mode flag. It returns a new sum/carry pair that holds four more Booth-weighted multiples of the multiplicand. The block is purely combinational. A surrounding sequencer feeds it successive multiplier windows, shifts the feedback and handles termination. A final carry-propagate adder resolves the pair into the product.

The window is split into four overlapping three-bit groups, and each group is recoded into a signed digit in the range -2..+2. Each digit selects zero, the multiplicand, or twice the multiplicand, moved left by two bits per digit position. Negative multiples are formed by inversion alone. The missing +1 of each two's-complement negation rides into the free least significant bit of the left-shifted carry vector of that digit's carry-save adder. Four carry-save adders in a chain therefore fold six operands into two, with no extra adder row.

The sequencer supplies the multiplier window with any bits above the multiplier's top already extended: zero for unsigned operation, copies of the sign bit for signed operation. The bit below multiplier bit 0 is supplied as 0.

Top module: `booth_csa_step`

## Requirements
- R1: Digit k (k = 0..3) is formed from the group {w[2k+1], w[2k], w[2k-1]}, where w[7:0] is `mult_win` and w[-1] is `mult_below`.
- R2: The digit value is w[2k] + w[2k-1] - 2*w[2k+1], which is always one of -2, -1, 0, +1, +2.
- R3: A -1 digit adds the bitwise inverse of the shifted multiplicand plus a pending +1. A -2 digit doubles and shifts the multiplicand before inverting it, so the shifted copy has a 1 at bit 2k before the pending +1 is added. This yields exactly -2*M*4^k.
- R4: Zero digits (groups 000 and 111) produce an all-zero addend with no pending +1. Positive digits produce no pending +1.
- R5: With `sgn_mode` = 1 the multiplicand is treated as two's complement and sign-extended to the working width. With `sgn_mode` = 0 it is zero-extended.
- R6: Modulo 2^ACC_W, `sum_out` + `carry_out` equals `sum_in` + `carry_in` + the sum over k of digit_k * M * 4^k.
- R7: Addend k carries weight 4^k, i.e. it is shifted left by 2k bits.
- R8: Each carry-save adder shifts its carry vector left by one bit and puts its digit's pending +1 into bit 0. So `carry_out[0]` is 1 exactly when digit 3 is negative.
- R9: A window that recodes to four zero digits (w = 0x00 with `mult_below` = 0, or w = 0xFF with `mult_below` = 1) leaves `sum_out` + `carry_out` equal to `sum_in` + `carry_in`, whatever the multiplicand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | 32 | Multiplicand |
| mult_win | input | 8 | Multiplier window for this step |
| mult_below | input | 1 | Multiplier bit just below the window |
| sgn_mode | input | 1 | 1 = signed operands, 0 = unsigned |
| sum_in | input | 66 | Partial sum fed back from the previous step |
| carry_in | input | 66 | Partial carry fed back from the previous step |
| sum_out | output | 66 | New partial sum |
| carry_out | output | 66 | New partial carry |

## Verification
The embedded checks assume that every input is a defined 0/1 value. They also assume that the feedback vectors may take any value, because conservation is stated modulo the working width. The stimulus draws every input with full-width random values and adds directed windows for each digit pattern and both modes. No legal input combination is excluded. The end-to-end reference is evaluated with signed integer digits rather than inverted vectors, so it is independent of the injection scheme.

// File: rtl/booth_csa_pkg.sv
// Package: shared Booth selection type and the group-to-digit recoding rule.
// Assumes three-bit groups ordered {upper, middle, lower}.
package booth_csa_pkg;

    typedef struct packed {
        logic neg;   // negative digit: invert, pending +1
        logic one;   // magnitude 1
        logic two;   // magnitude 2
    } booth_sel_t;

    // Recode one overlapping group into a signed-digit selection.
    function automatic booth_sel_t booth_recode(input logic [2:0] grp);
        booth_sel_t s;
        s = '0;
        unique case (grp)
            3'b000, 3'b111: s = '0;
            3'b001, 3'b010: s.one = 1'b1;
            3'b011:         s.two = 1'b1;
            3'b100:         begin s.neg = 1'b1; s.two = 1'b1; end
            3'b101, 3'b110: begin s.neg = 1'b1; s.one = 1'b1; end
            default:        s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/booth_digit_dec.sv
// Module: booth_digit_dec
// Turns one three-bit multiplier group into a signed-digit selection.
// Assumes the group is {w[2k+1], w[2k], w[2k-1]}.
module booth_digit_dec
    import booth_csa_pkg::*;
(
    input  logic [2:0] grp,
    output booth_sel_t sel
);

    // Recode the group.
    always_comb sel = booth_recode(grp);

    // Check the selection against the arithmetic digit value.
    always_comb begin
        AST_DIGIT_MAG_EXCL: assert (!(sel.one && sel.two))
            else $error("digit selects both magnitudes"); // R2
        AST_DIGIT_VALUE: assert ((int'(grp[1]) + int'(grp[0]) - 2*int'(grp[2]))
                                 == (sel.neg ? -1 : 1) * (sel.two ? 2 : (sel.one ? 1 : 0)))
            else $error("digit value mismatch"); // R1
        AST_ZERO_NO_NEG: assert (sel.one || sel.two || !sel.neg)
            else $error("zero digit has pending carry"); // R4
    end

endmodule

// File: rtl/booth_addend_gen.sv
// Module: booth_addend_gen
// Forms the addend for one digit: extend, scale by 1 or 2, shift by 2k,
// then invert for negative digits. The caller injects the pending +1.
// Assumes SHIFT + 1 + WIDTH <= ACC_W.
module booth_addend_gen
    import booth_csa_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int ACC_W = 66,
    parameter int SHIFT = 0
) (
    input  logic [WIDTH-1:0] mcand,
    input  logic             sgn_mode,
    input  booth_sel_t       sel,
    output logic [ACC_W-1:0] addend,
    output logic             pend_one
);

    localparam int EXT_W = ACC_W - WIDTH;

    logic [ACC_W-1:0] ext;
    logic [ACC_W-1:0] mag;
    logic [ACC_W-1:0] shifted;

    // Extend the multiplicand to the working width according to the mode.
    always_comb ext = {{EXT_W{sgn_mode & mcand[WIDTH-1]}}, mcand};

    // Select magnitude, weight it, then invert (shift before inversion).
    always_comb begin
        mag      = sel.two ? (ext << 1) : (sel.one ? ext : '0);
        shifted  = mag << SHIFT;
        addend   = sel.neg ? ~shifted : shifted;
        pend_one = sel.neg;
    end

    // Guard the negation ordering and the zero-digit addend.
    always_comb begin
        AST_NEG2_LSB_SET: assert (!(sel.neg && sel.two) || addend[SHIFT])
            else $error("-2 addend lacks a 1 at its weight bit"); // R3
        AST_ZERO_ADDEND: assert (sel.one || sel.two || (addend == '0 && !pend_one))
            else $error("zero digit gave a nonzero addend"); // R4
        AST_LOW_BITS_WEIGHT: assert (sel.neg || (addend & ((ACC_W'(1) << SHIFT) - ACC_W'(1))) == '0)
            else $error("positive addend below its weight"); // R7
    end

endmodule

// File: rtl/csa_cell.sv
// Module: csa_cell
// One 3:2 carry-save adder of working width, with a one-bit injection
// into the freed carry LSB. Assumes wrap-around modulo 2^ACC_W.
module csa_cell #(
    parameter int ACC_W = 66
) (
    input  logic [ACC_W-1:0] a,
    input  logic [ACC_W-1:0] b,
    input  logic [ACC_W-1:0] c,
    input  logic             inj,
    output logic [ACC_W-1:0] s,
    output logic [ACC_W-1:0] cy
);

    logic [ACC_W-1:0] maj;

    // Bitwise sum and majority; carry moves up one place, injection fills bit 0.
    always_comb begin
        s   = a ^ b ^ c;
        maj = (a & b) | (a & c) | (b & c);
        cy  = {maj[ACC_W-2:0], inj};
    end

    // The cell must conserve the arithmetic total of its operands.
    always_comb begin
        AST_CSA_CONSERVE: assert (ACC_W'(a + b + c + ACC_W'(inj)) == ACC_W'(s + cy))
            else $error("carry-save cell lost value"); // R6
        AST_INJECT_LSB: assert (cy[0] == inj)
            else $error("injection not at carry bit 0"); // R8
    end

endmodule

// File: rtl/booth_csa_step.sv
// Module: booth_csa_step (top)
// One combinational multiplier step: recode a window into DIGITS Booth
// digits, build the addends and fold them with the feedback through a
// chain of carry-save cells. Assumes the window is already extended above
// the multiplier top by the sequencer.
module booth_csa_step
    import booth_csa_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int DIGITS = 4,
    parameter int ACC_W  = 2*WIDTH + 2
) (
    input  logic [WIDTH-1:0]    mcand,
    input  logic [2*DIGITS-1:0] mult_win,
    input  logic                mult_below,
    input  logic                sgn_mode,
    input  logic [ACC_W-1:0]    sum_in,
    input  logic [ACC_W-1:0]    carry_in,
    output logic [ACC_W-1:0]    sum_out,
    output logic [ACC_W-1:0]    carry_out
);

    localparam int WIN_W = 2*DIGITS;

    logic [WIN_W:0]   win_ext;
    logic [ACC_W-1:0] sum_chain   [DIGITS+1];
    logic [ACC_W-1:0] carry_chain [DIGITS+1];

    // Append the bit below the window so every group is a plain slice.
    always_comb win_ext = {mult_win, mult_below};

    // Feedback enters the head of the chain.
    always_comb begin
        sum_chain[0]   = sum_in;
        carry_chain[0] = carry_in;
    end

    for (genvar k = 0; k < DIGITS; k++) begin : g_digit
        booth_sel_t       sel;
        logic [ACC_W-1:0] addend;
        logic             pend;

        booth_digit_dec u_dec (
            .grp (win_ext[2*k+2 -: 3]),
            .sel (sel)
        );

        booth_addend_gen #(
            .WIDTH (WIDTH),
            .ACC_W (ACC_W),
            .SHIFT (2*k)
        ) u_add (
            .mcand    (mcand),
            .sgn_mode (sgn_mode),
            .sel      (sel),
            .addend   (addend),
            .pend_one (pend)
        );

        csa_cell #(
            .ACC_W (ACC_W)
        ) u_csa (
            .a   (sum_chain[k]),
            .b   (carry_chain[k]),
            .c   (addend),
            .inj (pend),
            .s   (sum_chain[k+1]),
            .cy  (carry_chain[k+1])
        );
    end

    // The tail of the chain is the step result.
    always_comb begin
        sum_out   = sum_chain[DIGITS];
        carry_out = carry_chain[DIGITS];
    end

    // A window recoding to all-zero digits must leave the total untouched.
    always_comb begin
        AST_IDLE_WINDOW: assert (!((win_ext == '0) || (win_ext == '1))
                                 || ACC_W'(sum_out + carry_out) == ACC_W'(sum_in + carry_in))
            else $error("idle window changed the total"); // R9
        AST_TOP_CARRY_LSB: assert (carry_out[0] ==
                                   (win_ext[WIN_W] & ~(win_ext[WIN_W-1] & win_ext[WIN_W-2])))
            else $error("carry LSB does not track the top digit sign"); // R8
    end

endmodule

// File: tb/booth_csa_step_bench.sv
// Bench: drives the step with directed and random windows and compares the
// resolved total against a signed-digit integer reference every clock.
module booth_csa_step_bench;

    localparam int WIDTH  = 32;
    localparam int DIGITS = 4;
    localparam int ACC_W  = 2*WIDTH + 2;
    localparam int WIN_W  = 2*DIGITS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic [WIDTH-1:0] mcand;
    logic [WIN_W-1:0] mult_win;
    logic             mult_below;
    logic             sgn_mode;
    logic [ACC_W-1:0] sum_in, carry_in, sum_out, carry_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    booth_csa_step #(.WIDTH(WIDTH), .DIGITS(DIGITS), .ACC_W(ACC_W)) u_booth_csa_step (
        .mcand      (mcand),
        .mult_win   (mult_win),
        .mult_below (mult_below),
        .sgn_mode   (sgn_mode),
        .sum_in     (sum_in),
        .carry_in   (carry_in),
        .sum_out    (sum_out),
        .carry_out  (carry_out)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired act=%0d exp<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Integer digit of group k per the recoding rule.
    function automatic int digit_of(input logic [WIN_W-1:0] w, input logic lo, input int k);
        logic [WIN_W:0] e;
        e = {w, lo};
        return int'(e[2*k+1]) + int'(e[2*k]) - 2*int'(e[2*k+2]);
    endfunction

    // Reference total: feedback plus signed digits times the extended multiplicand.
    function automatic logic [ACC_W-1:0] ref_total(
        input logic [WIDTH-1:0] m, input logic [WIN_W-1:0] w, input logic lo,
        input logic sg, input logic [ACC_W-1:0] s, input logic [ACC_W-1:0] c);
        logic [ACC_W-1:0] t, mx, term;
        int d;
        t  = s + c;
        mx = sg ? {{(ACC_W-WIDTH){m[WIDTH-1]}}, m} : {{(ACC_W-WIDTH){1'b0}}, m};
        for (int k = 0; k < DIGITS; k++) begin
            d = digit_of(w, lo, k);
            term = mx << (2*k);
            if (d == 2 || d == -2) term = term << 1;
            if (d > 0) t = t + term;
            else if (d < 0) t = t - term;
        end
        return t;
    endfunction

    task automatic check(input string tag, input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp_v);
        checks = checks + 1;
        if (act !== exp_v) begin
            errors = errors + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp_v);
        end
    endtask

    // Apply one vector after a rising edge, check at the falling edge.
    task automatic apply(input logic [WIDTH-1:0] m, input logic [WIN_W-1:0] w, input logic lo,
                         input logic sg, input logic [ACC_W-1:0] s, input logic [ACC_W-1:0] c,
                         input string tag);
        logic top_neg;
        @(posedge clk);
        #1;
        mcand = m; mult_win = w; mult_below = lo; sgn_mode = sg; sum_in = s; carry_in = c;
        @(negedge clk);
        check({tag, " R6 total"}, ACC_W'(sum_out + carry_out), ref_total(m, w, lo, sg, s, c));
        top_neg = (digit_of(w, lo, DIGITS-1) < 0);
        check({tag, " R8 carry lsb"}, ACC_W'(carry_out[0]), ACC_W'(top_neg));
    endtask

    initial begin
        mcand = '0; mult_win = '0; mult_below = 1'b0; sgn_mode = 1'b0;
        sum_in = '0; carry_in = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: all-zero inputs give all-zero outputs.
        @(negedge clk);
        check("R4 idle sum", sum_out, '0);
        check("R4 idle carry", carry_out, '0);

        // R9: windows that recode to zero digits leave the total unchanged.
        apply(32'hDEADBEEF, 8'h00, 1'b0, 1'b1, 66'h1234, 66'h5678, "R9 zero win");
        check("R9 zero win keep", ACC_W'(sum_out + carry_out), 66'h68AC);
        apply(32'hDEADBEEF, 8'hFF, 1'b1, 1'b0, 66'h1111, 66'h2222, "R9 ones win");
        check("R9 ones win keep", ACC_W'(sum_out + carry_out), 66'h3333);

        // R3: single -1 digit at position 0 gives -M.
        apply(32'd5, 8'hFF, 1'b0, 1'b0, '0, '0, "R3 neg1");
        check("R3 neg1 value", ACC_W'(sum_out + carry_out), ACC_W'(0) - ACC_W'(5));
        // R3: single -2 digit at position 0 gives -2M.
        apply(32'd5, 8'hFE, 1'b0, 1'b0, '0, '0, "R3 neg2");
        check("R3 neg2 value", ACC_W'(sum_out + carry_out), ACC_W'(0) - ACC_W'(10));

        // R7: +1 digit at position 2 (w = 0x10) gives 16*M.
        apply(32'd3, 8'h10, 1'b0, 1'b0, '0, '0, "R7 weight");
        check("R7 weight value", ACC_W'(sum_out + carry_out), ACC_W'(48));

        // R1: bit below the window alone makes digit 0 equal +1.
        apply(32'd7, 8'h00, 1'b1, 1'b0, '0, '0, "R1 below");
        check("R1 below value", ACC_W'(sum_out + carry_out), ACC_W'(7));

        // R5: multiplicand with top bit set, +1 digit, both modes.
        apply(32'h8000_0000, 8'h01, 1'b0, 1'b0, '0, '0, "R5 unsigned");
        check("R5 unsigned value", ACC_W'(sum_out + carry_out), ACC_W'(64'h8000_0000));
        apply(32'h8000_0000, 8'h01, 1'b0, 1'b1, '0, '0, "R5 signed");
        check("R5 signed value", ACC_W'(sum_out + carry_out), ACC_W'(0) - ACC_W'(64'h8000_0000));

        // R8: top digit negative (w = 0x80) sets carry bit 0; +2 top digit does not.
        apply(32'd9, 8'h80, 1'b0, 1'b1, '0, '0, "R8 top neg");
        apply(32'd9, 8'h60, 1'b0, 1'b1, '0, '0, "R8 top pos");

        // R2: every window/below pattern once, fixed random multiplicand, both modes.
        for (int i = 0; i < 512; i++) begin
            apply(32'hA5C3_1F07, i[8:1], i[0], 1'b1, '0, '0, "R2 exhaustive signed");
            apply(32'hF00D_CAFE, i[8:1], i[0], 1'b0, 66'h3_0000_0000_0000_0001, '1, "R2 exhaustive unsigned");
        end

        // R6: random full-width vectors.
        for (int i = 0; i < 3000; i++) begin
            apply($urandom, 8'($urandom), 1'($urandom), 1'($urandom),
                  {2'($urandom), $urandom, $urandom}, {2'($urandom), $urandom, $urandom},
                  "R6 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule